// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits between a memory request stream and a set of DRAM bank controllers. Each incoming request carries a bank number, a row address, a read/write flag and an opaque tag. Requests are held in a small per-bank store. Every cycle the scheduler may hand at most one of them to a bank that reports itself idle. The aim is to keep rows open as long as useful work remains for them.

Within a bank, a request whose row matches the row the bank already has open is preferred. Once a row has been chosen, every queued request to that row goes out before any other row is considered. Among requests to one row, the oldest goes first. Banks take turns through a rotating priority pointer. An optional split mode holds reads and writes against separate capacities. In that mode writes are drained in bursts: write mode starts when pending writes reach a high mark and ends when they drop below a low mark. Counters of row hits and activations saturate and are brought out so that the classification can be observed.

Top module: `rhf_dram_sched`

## Requirements
- R1: After reset no dispatch is offered, `in_ready` is high for any bank and class, and both statistic counters read zero.
- R2: When a bank has no row chosen and holds a request of the current class whose row equals that bank's `open_row` slice, the oldest such request is dispatched with `disp_hit`=1, and `hit_count` rises by one.
- R3: When a bank has no row chosen and no queued request of the current class matches its open row, the oldest request of that class is dispatched with `disp_hit`=0, its row becomes the chosen row, and `act_count` rises by one.
- R4: A chosen row stays chosen until no request to it remains in that bank's current-class queue, even when older requests to other rows wait. Each of these follow-on dispatches reports `disp_hit`=1.
- R5: Requests to the same row in the same bank leave in arrival order.
- R6: At most one request is dispatched per cycle, and only to a bank whose `bank_idle` bit is 1. Banks are scanned upward (mod bank count) from the priority pointer, and the first idle bank with an eligible request wins.
- R7: After each dispatch the priority pointer advances by exactly one modulo the bank count, whichever bank was served. Without a dispatch it holds. It resets to bank 0.
- R8: `in_ready` is low when the addressed bank already stores BANK_DEPTH entries, or when the request's class has reached its capacity (RD_CAP reads, WR_CAP writes; with split mode off every request counts against RD_CAP).
- R9: With split mode on, the scheduler enters write mode when pending writes are at least WR_HI and returns to read mode when they are below WR_LO. Only requests of the current mode's class (`in_wr`=1 means write) are dispatched.
- R10: `hit_count` and `act_count` saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_bank | input | BANK_W | Target bank |
| in_row | input | ROW_W | Target row |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_tag | input | TAG_W | Opaque request identifier |
| bank_idle | input | NUM_BANKS | Per-bank: request slot free |
| open_row | input | NUM_BANKS*ROW_W | Per-bank currently open row, bank b at bits b*ROW_W upward |
| disp_valid | output | 1 | A request is dispatched this cycle |
| disp_bank | output | BANK_W | Bank of the dispatched request |
| disp_row | output | ROW_W | Row of the dispatched request |
| disp_wr | output | 1 | Write flag of the dispatched request |
| disp_tag | output | TAG_W | Tag of the dispatched request |
| disp_hit | output | 1 | 1 = row hit, 0 = activation |
| hit_count | output | STAT_W | Saturating row-hit count |
| act_count | output | STAT_W | Saturating activation count |

## Verification
On every cycle, the assertions check that no more than one bank is granted and that the granted bank is idle. They also check the pointer step and hold, that a fresh hit matches the open row, that a dispatch from a chosen row carries that row, that storage and class counts never overflow, and that every mode change obeys the watermark on the cycle it happens. The bench scenarios are the only place that can show the order requests leave in: hit-first choice, oldest-first inside a row, draining a chosen row ahead of an older request, and the rotation seen across several banks. The scenarios also show that `in_ready` falls at each limit, that hysteresis produces a burst of writes of the expected length, and that the counters stop at their ceiling.

// File: rtl/rhf_sched_pkg.sv
package rhf_sched_pkg;

  // Bank visited at step k of a scan that starts at ptr.
  function automatic int rr_slot(input int ptr, input int k, input int n);
    return (ptr + k) % n;
  endfunction

  // Pending-count update: one accept and one dispatch together cancel.
  function automatic int pend_next(input int cur, input logic inc, input logic dec);
    return cur + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // Hysteresis between read mode (0) and write mode (1).
  function automatic logic wr_mode_next(input logic cur, input int pend,
                                        input int hi, input int lo);
    if (!cur && pend >= hi) return 1'b1;
    if (cur && pend < lo)   return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/rhf_bank_store.sv
module rhf_bank_store #(
  parameter int DEPTH    = 4,
  parameter int ROW_W    = 4,
  parameter int TAG_W    = 8,
  parameter bit SPLIT_WR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [ROW_W-1:0] push_row_i,
  input  logic             push_wr_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             pop_i,
  input  logic             cls_i,
  input  logic [ROW_W-1:0] open_row_i,
  output logic             full_o,
  output logic             cand_o,
  output logic [ROW_W-1:0] pick_row_o,
  output logic             pick_wr_o,
  output logic [TAG_W-1:0] pick_tag_o,
  output logic             pick_hit_o
);
  localparam int IDX_W = $clog2(DEPTH);

  // Entries are packed from index 0 (oldest) upward.
  logic [DEPTH-1:0] ent_v, ent_wr;
  logic [ROW_W-1:0] ent_row [DEPTH];
  logic [TAG_W-1:0] ent_tag [DEPTH];
  logic [DEPTH-1:0] n_v, n_wr;
  logic [ROW_W-1:0] n_row [DEPTH];
  logic [TAG_W-1:0] n_tag [DEPTH];

  // One chosen row per class (0 = read queue, 1 = write queue).
  logic [1:0]       sel_v;
  logic [ROW_W-1:0] sel_row [2];

  logic [DEPTH-1:0] any_c, m_sel, m_open, pick_vec;
  logic             use_sel, use_open, found, keep_sel, placed;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      any_c[i]  = ent_v[i] && ((SPLIT_WR ? ent_wr[i] : 1'b0) == cls_i);
      m_sel[i]  = any_c[i] && sel_v[cls_i] && (ent_row[i] == sel_row[cls_i]);
      m_open[i] = any_c[i] && (ent_row[i] == open_row_i);
    end
  end

  always_comb begin
    use_sel  = sel_v[cls_i] && (|m_sel);
    use_open = !use_sel && (|m_open);
    pick_vec = use_sel ? m_sel : (use_open ? m_open : any_c);
    pick_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pick_vec[i] && !found) begin
        pick_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  assign cand_o     = |any_c;
  assign full_o     = &ent_v;
  assign pick_row_o = ent_row[pick_idx];
  assign pick_wr_o  = ent_wr[pick_idx];
  assign pick_tag_o = ent_tag[pick_idx];
  assign pick_hit_o = use_sel || use_open;

  // Does the chosen row still have work after this dispatch?
  always_comb begin
    keep_sel = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (any_c[i] && ent_row[i] == pick_row_o && i != int'(pick_idx)) keep_sel = 1'b1;
    end
  end

  // Remove the picked entry by compaction, then append the new one.
  always_comb begin
    n_v   = ent_v;
    n_wr  = ent_wr;
    n_row = ent_row;
    n_tag = ent_tag;
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(pick_idx)) begin
          n_v[i]   = ent_v[i+1];
          n_wr[i]  = ent_wr[i+1];
          n_row[i] = ent_row[i+1];
          n_tag[i] = ent_tag[i+1];
        end
      end
      n_v[DEPTH-1] = 1'b0;
    end
    placed = 1'b0;
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!n_v[i] && !placed) begin
          n_v[i]   = 1'b1;
          n_wr[i]  = push_wr_i;
          n_row[i] = push_row_i;
          n_tag[i] = push_tag_i;
          placed   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      ent_wr <= '0;
      sel_v  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_row[i] <= '0;
        ent_tag[i] <= '0;
      end
      for (int c = 0; c < 2; c++) sel_row[c] <= '0;
    end else begin
      ent_v  <= n_v;
      ent_wr <= n_wr;
      ent_row <= n_row;
      ent_tag <= n_tag;
      if (pop_i) begin
        sel_v[cls_i]   <= keep_sel;
        sel_row[cls_i] <= pick_row_o;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o || pop_i); // R8
  AST_HIT_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && pick_hit_o && !sel_v[cls_i] |-> pick_row_o == open_row_i); // R2
  AST_STICKY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && sel_v[cls_i] |-> pick_row_o == sel_row[cls_i] && pick_hit_o); // R4

endmodule

// File: rtl/rhf_rr_pick.sv
module rhf_rr_pick
  import rhf_sched_pkg::*;
#(
  parameter  int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic [N-1:0] gnt_o,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any_o && req_i[rr_slot(int'(ptr_i), k, N)]) begin
        any_o = 1'b1;
        idx_o = W'(rr_slot(int'(ptr_i), k, N));
        gnt_o[rr_slot(int'(ptr_i), k, N)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rhf_dram_sched.sv
module rhf_dram_sched
  import rhf_sched_pkg::*;
#(
  parameter  int NUM_BANKS  = 4,
  parameter  int BANK_DEPTH = 4,
  parameter  int ROW_W      = 4,
  parameter  int TAG_W      = 8,
  parameter  bit SPLIT_WR   = 1'b1,
  parameter  int RD_CAP     = 8,
  parameter  int WR_CAP     = 6,
  parameter  int WR_HI      = 4,
  parameter  int WR_LO      = 2,
  parameter  int STAT_W     = 8,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [BANK_W-1:0]          in_bank,
  input  logic [ROW_W-1:0]           in_row,
  input  logic                       in_wr,
  input  logic [TAG_W-1:0]           in_tag,
  input  logic [NUM_BANKS-1:0]       bank_idle,
  input  logic [NUM_BANKS*ROW_W-1:0] open_row,
  output logic                       disp_valid,
  output logic [BANK_W-1:0]          disp_bank,
  output logic [ROW_W-1:0]           disp_row,
  output logic                       disp_wr,
  output logic [TAG_W-1:0]           disp_tag,
  output logic                       disp_hit,
  output logic [STAT_W-1:0]          hit_count,
  output logic [STAT_W-1:0]          act_count
);
  localparam int RD_CW = $clog2(RD_CAP + 1);
  localparam int WR_CW = $clog2(WR_CAP + 1);

  logic [RD_CW-1:0]     rd_cnt;
  logic [WR_CW-1:0]     wr_cnt;
  logic [BANK_W-1:0]    prio_q;
  logic                 wr_mode_q, wr_mode_now;
  logic [NUM_BANKS-1:0] bank_full, bank_cand, bank_req, gnt, push_b;
  logic [ROW_W-1:0]     pick_row_a [NUM_BANKS];
  logic [TAG_W-1:0]     pick_tag_a [NUM_BANKS];
  logic [NUM_BANKS-1:0] pick_wr_a, pick_hit_a;
  logic                 in_cls, cls_full, accept, disp_cls;

  assign wr_mode_now = SPLIT_WR ? wr_mode_next(wr_mode_q, int'(wr_cnt), WR_HI, WR_LO) : 1'b0;
  assign in_cls      = SPLIT_WR ? in_wr : 1'b0;
  assign cls_full    = in_cls ? (int'(wr_cnt) >= WR_CAP) : (int'(rd_cnt) >= RD_CAP);
  assign in_ready    = !bank_full[in_bank] && !cls_full;
  assign accept      = in_valid && in_ready;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign push_b[g]   = accept && (in_bank == BANK_W'(g));
    assign bank_req[g] = bank_cand[g] && bank_idle[g];
    rhf_bank_store #(
      .DEPTH(BANK_DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W), .SPLIT_WR(SPLIT_WR)
    ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push_b[g]),
      .push_row_i (in_row),
      .push_wr_i  (in_wr),
      .push_tag_i (in_tag),
      .pop_i      (gnt[g]),
      .cls_i      (wr_mode_now),
      .open_row_i (open_row[g*ROW_W +: ROW_W]),
      .full_o     (bank_full[g]),
      .cand_o     (bank_cand[g]),
      .pick_row_o (pick_row_a[g]),
      .pick_wr_o  (pick_wr_a[g]),
      .pick_tag_o (pick_tag_a[g]),
      .pick_hit_o (pick_hit_a[g])
    );
  end

  rhf_rr_pick #(.N(NUM_BANKS)) arb_i (
    .req_i (bank_req),
    .ptr_i (prio_q),
    .gnt_o (gnt),
    .idx_o (disp_bank),
    .any_o (disp_valid)
  );

  assign disp_row = pick_row_a[disp_bank];
  assign disp_wr  = pick_wr_a[disp_bank];
  assign disp_tag = pick_tag_a[disp_bank];
  assign disp_hit = pick_hit_a[disp_bank];
  assign disp_cls = SPLIT_WR ? disp_wr : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      prio_q    <= '0;
      wr_mode_q <= 1'b0;
      hit_count <= '0;
      act_count <= '0;
    end else begin
      rd_cnt    <= RD_CW'(pend_next(int'(rd_cnt), accept && !in_cls, disp_valid && !disp_cls));
      wr_cnt    <= WR_CW'(pend_next(int'(wr_cnt), accept && in_cls, disp_valid && disp_cls));
      wr_mode_q <= wr_mode_now;
      if (disp_valid) begin
        prio_q <= BANK_W'(rr_slot(int'(prio_q), 1, NUM_BANKS));
        if (disp_hit && hit_count != '1)  hit_count <= hit_count + 1'b1;
        if (!disp_hit && act_count != '1) act_count <= act_count + 1'b1;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R6
  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> bank_idle[disp_bank] && gnt[disp_bank]); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> int'(prio_q) == rr_slot(int'($past(prio_q)), 1, NUM_BANKS)); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |=> $stable(prio_q)); // R7
  AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_cnt) <= RD_CAP); // R8
  AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_cnt) <= WR_CAP); // R8
  AST_MODE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_mode_q) |-> int'($past(wr_cnt)) >= WR_HI); // R9
  AST_MODE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_mode_q) |-> int'($past(wr_cnt)) < WR_LO); // R9
  AST_MODE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && SPLIT_WR |-> disp_wr == wr_mode_now); // R9
  AST_HIT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count == '1 |=> hit_count == '1); // R10
  AST_ACT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    act_count == '1 |=> act_count == '1); // R10

endmodule

// File: tb/rhf_dram_sched_tb_top.sv
module rhf_dram_sched_tb_top;
  localparam int NB = 4;
  localparam int RW = 4;
  localparam int TW = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_bank = '0;
  logic [RW-1:0] in_row = '0;
  logic          in_wr = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [NB-1:0] bank_idle = '0;
  logic [NB*RW-1:0] open_row = '0;
  logic          disp_valid, disp_wr, disp_hit;
  logic [1:0]    disp_bank;
  logic [RW-1:0] disp_row;
  logic [TW-1:0] disp_tag;
  logic [SW-1:0] hit_count, act_count;

  int n_chk = 0;
  int n_bad = 0;
  int exp_ptr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rhf_dram_sched #(
    .NUM_BANKS(NB), .BANK_DEPTH(4), .ROW_W(RW), .TAG_W(TW), .SPLIT_WR(1'b1),
    .RD_CAP(8), .WR_CAP(6), .WR_HI(4), .WR_LO(2), .STAT_W(SW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bank(in_bank), .in_row(in_row), .in_wr(in_wr), .in_tag(in_tag),
    .bank_idle(bank_idle), .open_row(open_row), .disp_valid(disp_valid),
    .disp_bank(disp_bank), .disp_row(disp_row), .disp_wr(disp_wr),
    .disp_tag(disp_tag), .disp_hit(disp_hit), .hit_count(hit_count),
    .act_count(act_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input int b, input int row, input bit wr, input int tag);
    in_valid = 1'b1; in_bank = 2'(b); in_row = RW'(row); in_wr = wr; in_tag = TW'(tag);
    #1 check("R8 ready while space", int'(in_ready), 1);
    step();
    in_valid = 1'b0;
  endtask

  task automatic probe_ready(input string req, input int b, input bit wr, input int exp);
    in_valid = 1'b0; in_bank = 2'(b); in_wr = wr;
    #1 check(req, int'(in_ready), exp);
  endtask

  task automatic expect_disp(input string req, input int b, input int row, input int tag, input int hit);
    #1;
    check({req, " valid"}, int'(disp_valid), 1);
    check({req, " bank"}, int'(disp_bank), b);
    check({req, " row"}, int'(disp_row), row);
    check({req, " tag"}, int'(disp_tag), tag);
    check({req, " hit"}, int'(disp_hit), hit);
    if (disp_valid) exp_ptr = (exp_ptr + 1) % NB;
    step();
  endtask

  task automatic expect_none(input string req);
    #1 check(req, int'(disp_valid), 0);
    step();
  endtask

  task automatic expect_cls(input string req, input int wr);
    #1;
    check({req, " valid"}, int'(disp_valid), 1);
    check({req, " class"}, int'(disp_wr), wr);
    if (disp_valid) exp_ptr = (exp_ptr + 1) % NB;
    step();
  endtask

  initial begin
    int pend [NB];
    int got;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 no dispatch", int'(disp_valid), 0);
    check("R1 ready", int'(in_ready), 1);
    check("R1 hit_count", int'(hit_count), 0);
    check("R1 act_count", int'(act_count), 0);
    @(negedge clk);

    // R2, R4, R5, R3 in bank 0: open row 5
    open_row[0 +: RW] = 4'd5;
    push(0, 3, 0, 1); push(0, 5, 0, 2); push(0, 3, 0, 3); push(0, 5, 0, 4);
    bank_idle = 4'b0001;
    expect_disp("R2 open-row hit first", 0, 5, 2, 1);
    expect_disp("R5 same row oldest next", 0, 5, 4, 1);
    expect_disp("R3 miss takes oldest", 0, 3, 1, 0);
    expect_disp("R4 follow-on counts hit", 0, 3, 3, 1);
    expect_none("R6 empty bank idle");

    // R4 chosen row drains ahead of an older other-row request, bank 1 open row 9
    bank_idle = '0;
    open_row[RW +: RW] = 4'd9;
    push(1, 1, 0, 10); push(1, 2, 0, 11); push(1, 1, 0, 12);
    bank_idle = 4'b0010;
    expect_disp("R3 miss picks oldest row", 1, 1, 10, 0);
    expect_disp("R4 chosen row beats older", 1, 1, 12, 1);
    expect_disp("R3 next miss", 1, 2, 11, 0);
    expect_none("R6 bank1 drained");
    check("R2 hit_count", int'(hit_count), 4);
    check("R3 act_count", int'(act_count), 3);

    // R6, R7 rotation across banks, one request each, open row = bank
    bank_idle = '0;
    for (int b = 0; b < NB; b++) begin
      open_row[b*RW +: RW] = RW'(b);
      push(b, b, 0, 20 + b);
      pend[b] = 1;
    end
    for (int c = 0; c < NB; c++) begin
      int eb;
      bank_idle = '1;
      if (c == 0) bank_idle[exp_ptr] = 1'b0;
      eb = -1;
      for (int k = 0; k < NB; k++) begin
        int b;
        b = (exp_ptr + k) % NB;
        if (eb < 0 && pend[b] != 0 && bank_idle[b]) eb = b;
      end
      pend[eb] = 0;
      expect_disp("R7 rotation order", eb, eb, 20 + eb, 1);
    end
    expect_none("R6 all drained");
    check("R10 hit_count saturates", int'(hit_count), 7);
    check("R10 act_count steady", int'(act_count), 3);

    // R8 bank depth and read capacity
    bank_idle = '0;
    for (int i = 0; i < 4; i++) push(2, 0, 0, 40 + i);
    probe_ready("R8 bank full blocks", 2, 0, 0);
    probe_ready("R8 other bank open", 3, 0, 1);
    for (int i = 0; i < 4; i++) push(0, 0, 0, 50 + i);
    probe_ready("R8 read cap blocks", 3, 0, 0);
    probe_ready("R8 write cap separate", 3, 1, 1);
    bank_idle = '1;
    got = 0;
    for (int i = 0; i < 12; i++) begin
      #1;
      if (disp_valid) begin got++; exp_ptr = (exp_ptr + 1) % NB; end
      step();
    end
    check("R6 one per cycle drains eight", got, 8);
    probe_ready("R8 ready after drain", 2, 0, 1);

    // R9 write-mode hysteresis: HI=4, LO=2
    bank_idle = '0;
    push(0, 1, 1, 60); push(0, 1, 1, 61); push(0, 1, 1, 62);
    push(1, 7, 0, 70); push(1, 7, 0, 71);
    bank_idle = '1;
    expect_cls("R9 read mode below high mark", 0);
    expect_cls("R9 read mode second", 0);
    expect_none("R9 writes held in read mode");
    bank_idle = '0;
    push(0, 1, 1, 63); push(1, 7, 0, 72); push(1, 7, 0, 73);
    bank_idle = '1;
    expect_cls("R9 write burst 1", 1);
    expect_cls("R9 write burst 2", 1);
    expect_cls("R9 write burst 3", 1);
    expect_cls("R9 back to reads", 0);
    expect_cls("R9 reads continue", 0);
    expect_none("R9 last write held");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule